// File: doc/BRIEF.md
# Serial ADC Sample Formatter

This block turns parallel converter samples from several channels into serial bit streams, one frame per sample. Besides the data lanes it generates a frame marker and a data clock, so a receiver can find word boundaries and capture bits. It runs on a bit-rate clock, so one clock cycle is one bit time.

A static strap picks the lane layout for each channel. With two lanes, the word is split across a lane pair, which keeps the bit rate low. With one lane, the whole word goes out serially. The strap is only sampled between words, so a change never cuts a word short. A test-mode selector can replace the converter data with a fixed marker word or a pseudo-random word from a 9-bit or 23-bit LFSR. The frame marker and data clock keep running exactly as in normal operation. A sign-format option inverts the MSB of words that go through the formatting stage. Pseudo-random words bypass that stage.

Samples enter on a valid/ready port. Ready is asserted for exactly one cycle per frame, the last bit time of the current frame. A word is accepted when valid is high in that cycle. The block never waits for a sample. If valid is low at that moment, the next frame carries an idle word. The upstream side therefore must present data when ready rises, and holding valid has no effect outside that cycle.

Top module: `adc_serial_formatter`

## Requirements
- R1: With `lane_mode` high (two-lane), a frame lasts W/2 bit times. In bit time k (k = 0 first), `lane1` carries word bit W-1-2k and `lane0` carries bit W-2-2k. So odd-indexed bits go on lane 1 and even-indexed bits on lane 0, MSB first.
- R2: With `lane_mode` low (one-lane), a frame lasts W bit times. In bit time k, `lane0` carries word bit W-1-k and `lane1` stays low.
- R3: `fco` is high for the first half of each frame's bit times and low for the second half. `dco` is low in even bit times and high in odd bit times, counted from 0 at the start of each frame.
- R4: `in_ready` is high only in the last bit time of each frame. A word with `in_valid` high in that cycle goes out in the next frame. If `in_valid` is low, the next frame carries an all-zero word before formatting.
- R5: After reset the block is in two-lane mode. `lane_mode` is sampled only in the cycle where `in_ready` is high, so a change in the middle of a frame alters neither that frame's length nor its bits.
- R6: `test_mode` 1 (fixed pattern) sends the word with only bit W-1 set (1000 0000 0000 for W=12) on every channel.
- R7: `test_mode` 2 sends the 9-bit LFSR state x^9+x^5+1, zero-extended to W bits. The next state is {state[7:0], state[8]^state[4]}, and the LFSR advances once per frame in every mode.
- R8: `test_mode` 3 sends the low W bits of the 23-bit LFSR state x^23+x^18+1. The next state is {state[21:0], state[22]^state[17]}, and the LFSR advances once per frame.
- R9: Both LFSRs start at all ones after reset. While `pn9_reseed` or `pn23_reseed` is high, the matching LFSR is forced to all ones.
- R10: `fmt_twos` high inverts bit W-1 of normal, idle and fixed-pattern words. Pseudo-random words are sent unchanged.
- R11: In test modes 1 to 3, `in_data` has no effect on the lanes, and `in_ready` keeps pulsing once per frame.
- R12: During and right after reset, all lanes are low, `in_ready` is low, `fco` is high and `dco` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Sample accepted this cycle (last bit time of frame) |
| in_data | input | NCH*W | Channel samples, channel c at bits [c*W +: W] |
| lane_mode | input | 1 | Strap: 1 two-lane, 0 one-lane |
| test_mode | input | 2 | 0 normal, 1 fixed word, 2 PN9, 3 PN23 |
| fmt_twos | input | 1 | Invert MSB of formatted words |
| pn9_reseed | input | 1 | Force 9-bit LFSR to all ones |
| pn23_reseed | input | 1 | Force 23-bit LFSR to all ones |
| lane0 | output | NCH | Lane 0 serial bit per channel |
| lane1 | output | NCH | Lane 1 serial bit per channel |
| fco | output | 1 | Frame marker |
| dco | output | 1 | Data clock, half the bit rate |

## Verification
The bench builds the block with three channels and W=12. A third channel shows that the per-channel generate copies stay independent under random data. Keeping W at 12 gives frames of 6 and 12 bit times, so both lane layouts and strap flips in the middle of a frame run in a short test. Directed frames cover the idle word, every test mode with and without MSB inversion, and both LFSR reseeds. A long random mix of modes, straps and valid gaps follows, so the LFSR models track hundreds of steps.

// File: rtl/adc_sfmt_pkg.sv
package adc_sfmt_pkg;
  typedef enum logic [1:0] {
    TM_OFF   = 2'd0,
    TM_FIXED = 2'd1,
    TM_PN9   = 2'd2,
    TM_PN23  = 2'd3
  } tmode_e;
endpackage

// File: rtl/sfmt_frame_timer.sv
module sfmt_frame_timer #(
  parameter int W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lane_mode,
  output logic two_q,
  output logic boundary,
  output logic fco,
  output logic dco
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST1 = CW'(W - 1);
  localparam logic [CW-1:0] LAST2 = CW'(W / 2 - 1);
  localparam logic [CW-1:0] HALF1 = CW'(W / 2);
  localparam logic [CW-1:0] HALF2 = CW'(W / 4);

  logic [CW-1:0] cnt;

  assign boundary = (cnt == (two_q ? LAST2 : LAST1));
  assign fco      = (cnt < (two_q ? HALF2 : HALF1));
  assign dco      = cnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      two_q <= 1'b1;
    end else if (boundary) begin
      cnt   <= '0;
      two_q <= lane_mode;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R3: every frame opens with the marker high and the data clock low
  a_r3_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (fco && !dco));
  // R5: lane layout changes only across a frame boundary
  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(two_q));
  // R4: bit counter never runs past the longest frame
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST1);
endmodule

// File: rtl/sfmt_pn_gen.sv
module sfmt_pn_gen #(
  parameter int LEN = 9,
  parameter int TAP = 5,
  parameter int W   = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         seed_now,
  output logic [W-1:0] word
);
  logic [LEN-1:0] state;
  logic           fb;

  assign fb   = state[LEN-1] ^ state[TAP-1];
  assign word = W'(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= '1;
    else if (seed_now) state <= '1;
    else if (step)     state <= {state[LEN-2:0], fb};
  end

  // R9: a reseed request leaves the register at all ones
  a_r9_seed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    seed_now |=> (state == '1));
  // R7: a maximal-length XOR LFSR seeded with ones never reaches zero
  a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/sfmt_word_sel.sv
module sfmt_word_sel
  import adc_sfmt_pkg::*;
#(
  parameter int W = 12
) (
  input  tmode_e       tm,
  input  logic         vld,
  input  logic [W-1:0] data,
  input  logic [W-1:0] pn9_w,
  input  logic [W-1:0] pn23_w,
  input  logic         twos,
  output logic [W-1:0] word
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] base;
  logic         formatted;

  always_comb begin
    unique case (tm)
      TM_OFF:   begin base = vld ? data : '0; formatted = 1'b1; end
      TM_FIXED: begin base = MSB_ONLY;        formatted = 1'b1; end
      TM_PN9:   begin base = pn9_w;           formatted = 1'b0; end
      default:  begin base = pn23_w;          formatted = 1'b0; end
    endcase
    word = (formatted && twos) ? (base ^ MSB_ONLY) : base;
  end
endmodule

// File: rtl/sfmt_lane_ser.sv
module sfmt_lane_ser #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         two_q,
  input  logic [W-1:0] word,
  output logic         l0,
  output logic         l1
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= word;
    else if (two_q) sh <= sh << 2;
    else            sh <= sh << 1;
  end

  assign l1 = two_q ? sh[W-1] : 1'b0;
  assign l0 = two_q ? sh[W-2] : sh[W-1];
endmodule

// File: rtl/adc_serial_formatter.sv
module adc_serial_formatter
  import adc_sfmt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NCH*W-1:0] in_data,
  input  logic             lane_mode,
  input  logic [1:0]       test_mode,
  input  logic             fmt_twos,
  input  logic             pn9_reseed,
  input  logic             pn23_reseed,
  output logic [NCH-1:0]   lane0,
  output logic [NCH-1:0]   lane1,
  output logic             fco,
  output logic             dco
);
  tmode_e       tm;
  logic         two_q;
  logic         boundary;
  logic [W-1:0] pn9_w;
  logic [W-1:0] pn23_w;

  assign tm       = tmode_e'(test_mode);
  assign in_ready = boundary;

  sfmt_frame_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
    .two_q(two_q), .boundary(boundary), .fco(fco), .dco(dco)
  );

  sfmt_pn_gen #(.LEN(9), .TAP(5), .W(W)) u_pn9 (
    .clk(clk), .rst_n(rst_n), .step(boundary),
    .seed_now(pn9_reseed), .word(pn9_w)
  );

  sfmt_pn_gen #(.LEN(23), .TAP(18), .W(W)) u_pn23 (
    .clk(clk), .rst_n(rst_n), .step(boundary),
    .seed_now(pn23_reseed), .word(pn23_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] word;

    sfmt_word_sel #(.W(W)) u_sel (
      .tm(tm), .vld(in_valid), .data(in_data[c*W +: W]),
      .pn9_w(pn9_w), .pn23_w(pn23_w), .twos(fmt_twos), .word(word)
    );

    sfmt_lane_ser #(.W(W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(boundary), .two_q(two_q),
      .word(word), .l0(lane0[c]), .l1(lane1[c])
    );
  end

  // R6: fixed word leads with a one on the MSB lane, zero on the other (R1 layout)
  a_r6_fixed_two: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && tm == TM_FIXED && !fmt_twos && lane_mode) |=>
      (lane1 == '1 && lane0 == '0));
  // R2: one-lane fixed word leads with a one on lane 0, lane 1 silent
  a_r2_fixed_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && tm == TM_FIXED && !fmt_twos && !lane_mode) |=>
      (lane0 == '1 && lane1 == '0));
endmodule

// File: tb/adc_serial_formatter_test.sv
module adc_serial_formatter_test;
  localparam int  NCH    = 3;
  localparam int  W      = 12;
  localparam time PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [NCH*W-1:0] in_data;
  logic             lane_mode;
  logic [1:0]       test_mode;
  logic             fmt_twos;
  logic             pn9_reseed;
  logic             pn23_reseed;
  logic [NCH-1:0]   lane0;
  logic [NCH-1:0]   lane1;
  logic             fco;
  logic             dco;

  int checks = 0;
  int fails  = 0;
  logic [8:0]  m9  = '1;
  logic [22:0] m23 = '1;

  always #(PERIOD/2) clk = ~clk;

  adc_serial_formatter #(.NCH(NCH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_mode(lane_mode), .test_mode(test_mode),
    .fmt_twos(fmt_twos), .pn9_reseed(pn9_reseed), .pn23_reseed(pn23_reseed),
    .lane0(lane0), .lane1(lane1), .fco(fco), .dco(dco)
  );

  function automatic logic [8:0] step9(logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [22:0] step23(logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [W-1:0] exp_word(logic [1:0] tm, logic vld,
      logic [W-1:0] d, logic tw);
    logic [W-1:0] msb = {1'b1, {(W-1){1'b0}}};
    case (tm)
      2'd0:    return (vld ? d : '0) ^ (tw ? msb : '0);
      2'd1:    return msb ^ (tw ? msb : '0);
      2'd2:    return W'(m9);
      default: return m23[W-1:0];
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge where in_ready is high.
  task automatic frame(string tag, logic [1:0] tm, logic lm, logic tw,
      logic vld, logic r9, logic r23, logic flip);
    logic [W-1:0] ew [NCH];
    logic [NCH-1:0] e0, e1;
    int n;
    for (int c = 0; c < NCH; c++) in_data[c*W +: W] = W'($urandom);
    in_valid = vld; test_mode = tm; lane_mode = lm; fmt_twos = tw;
    pn9_reseed = r9; pn23_reseed = r23;
    for (int c = 0; c < NCH; c++) ew[c] = exp_word(tm, vld, in_data[c*W +: W], tw);
    m9  = r9  ? '1 : step9(m9);
    m23 = r23 ? '1 : step23(m23);
    n = lm ? W/2 : W;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin pn9_reseed = 1'b0; pn23_reseed = 1'b0; end
      if (flip && k == 2) lane_mode = ~lm;
      for (int c = 0; c < NCH; c++) begin
        if (lm) begin e1[c] = ew[c][W-1-2*k]; e0[c] = ew[c][W-2-2*k]; end
        else    begin e1[c] = 1'b0;           e0[c] = ew[c][W-1-k];   end
      end
      chk(tag, 64'({lane0, lane1, fco, dco, in_ready}),
          64'({e0, e1, k < n/2, k[0], k == n-1}));
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int guard;
    void'($urandom(32'h5EED_0C0D));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; lane_mode = 1'b1;
    test_mode = 2'd0; fmt_twos = 1'b0; pn9_reseed = 1'b0; pn23_reseed = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset", 64'({lane0, lane1, fco, dco, in_ready}),
        64'({{NCH{1'b0}}, {NCH{1'b0}}, 1'b1, 1'b0, 1'b0}));
    rst_n = 1'b1;
    guard = 0;
    while (!in_ready && guard < 20) begin @(negedge clk); guard++; end
    // R5: first frame after reset is two-lane (ready after W/2 bit times)
    chk("R5 default two-lane", 64'(guard), 64'(W/2 - 1));
    chk("R12 idle lanes", 64'({lane0, lane1}), 64'(0));

    frame("R1 two-lane data",     2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R2 one-lane data",     2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R4 idle word",         2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    frame("R10 idle twos",        2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    frame("R10 data twos",        2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R6 fixed two-lane",    2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R6 fixed one-lane",    2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R10 fixed twos",       2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    frame("R7 pn9",               2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R9 pn9 reseed",        2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    frame("R9 pn9 after reseed",  2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R8 pn23",              2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R10 pn23 bypass",      2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R9 pn23 reseed",       2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    frame("R9 pn23 after reseed", 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R11 test ignores data",2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame("R5 flip mid two-lane", 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    frame("R5 flip mid one-lane", 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    frame("R3 after flip",        2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      frame("R3 random mix", 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 16) == 0, ($urandom % 16) == 0,
            ($urandom % 8) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule